// File: doc/BRIEF.md
# Trap Entry Controller

This block performs the architectural state update of a hart at the moment a trap is taken. It receives a single-cycle trap request that carries a code, an interrupt flag and a non-maskable flag, together with the faulting PC, a trap value and the extension bits of the hart. It decides which privilege level will handle the trap. It then writes that level's cause, exception-PC and trap-value registers and its status fields, and redirects the PC to the handler. Machine, supervisor and user level handling are supported. Handler selection runs in two delegation stages: machine to supervisor, then supervisor to user for traps raised in user mode.

A resumable non-maskable interrupt has its own cause, exception-PC and status registers, so the machine status word of an interrupted machine handler is kept. The block also holds the reset state of the privilege, the PC and the vector configuration. A small select/write/read port loads the delegation masks, the vector bases and the privilege, and reads all held state back. Trap return, instruction decode and the memory system lie outside the block. The `trap_taken` strobe also serves as the load-reservation invalidate.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is applied and after it is released, the privilege is machine (3), the PC equals RESET_VEC, the status word is 0 (machine interrupt enable and modify-privilege cleared), the vector-illegal flag is 1, the vector length is 0, and the NMI-enable bit is 1.
- R2: An NMI goes to machine level whatever the delegation state, jumps to NMI_VEC and clears the NMI-enable bit. An NMI request that arrives while NMI-enable is 0 is not taken: no strobe, no state change.
- R3: A trap raised below machine level whose code bit is set in the machine-level mask is delegated. Interrupts use the interrupt mask and exceptions use the exception mask. It goes to supervisor (1) if the supervisor extension is present, else to user (0) if the user-interrupt extension is present, else to machine. A trap raised at machine level is never delegated.
- R4: A trap raised in user mode that stage one sends to supervisor is lowered to user when both extensions are present and its code bit is set in the matching supervisor-level mask.
- R5: Supervisor entry sets SPP (status bit 6) to bit 0 of the previous privilege, copies SIE (bit 1) into SPIE (bit 4) and clears SIE. User entry copies UIE (bit 0) into UPIE (bit 3) and clears UIE. All other status bits are kept.
- R6: Machine entry for a trap that is not a resumable NMI sets MPP (bits 8:7) to the previous privilege, copies MIE (bit 2) into MPIE (bit 5) and clears MIE.
- R7: A resumable NMI (NMI with `ext_rnmi` set) writes the NMI cause and NMI exception-PC registers instead of the machine ones. It puts the previous privilege into the NMI status bits 1:0 and leaves the status word and the machine cause unchanged.
- R8: The cause value is the code in the low bits, with bit XLEN-1 set for interrupts and NMIs.
- R9: The saved exception PC is `trap_pc`, or `tbl_pc` when `tbl_second` flags the second fetch of a table jump.
- R10: A taken trap writes `trap_val` into the selected level's trap-value register (machine level for any NMI). The privilege and PC change on the edge after the request, and `trap_taken` is high for exactly that one cycle.
- R11: The handler PC is the selected vector base with bits 1:0 cleared. If the vector's bits 1:0 equal 01 and the trap is an ordinary interrupt, 4 times the code is added.
- R12: Select codes: 0 status, 1/2 machine exception/interrupt mask, 3/4 supervisor exception/interrupt mask, 5/6/7 machine/supervisor/user vector, 8-10 machine cause/EPC/tval, 11-13 supervisor, 14-16 user, 17/18 NMI cause/EPC, 19 NMI status (bits 1:0 previous privilege, bit 2 NMI-enable), 20 privilege. A write takes effect on the next edge when no trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_req | input | 1 | Single-cycle trap request |
| trap_irq | input | 1 | Request is an interrupt |
| trap_nmi | input | 1 | Request is a non-maskable interrupt |
| trap_code | input | CODE_W | Exception or interrupt code |
| trap_pc | input | XLEN | Address of the trapping instruction |
| tbl_second | input | 1 | Trap hit the second fetch of a table jump |
| tbl_pc | input | XLEN | Address of that table-jump instruction |
| trap_val | input | XLEN | Trap value |
| ext_s | input | 1 | Supervisor extension present |
| ext_u_irq | input | 1 | User-level interrupt extension present |
| ext_rnmi | input | 1 | Resumable NMI extension enabled |
| csr_we | input | 1 | State write strobe |
| csr_sel | input | 5 | State select code |
| csr_wdata | input | XLEN | State write data |
| csr_rdata | output | XLEN | Selected state, read combinationally |
| priv_lvl | output | 2 | Current privilege |
| pc_out | output | XLEN | Current PC (handler PC after a trap) |
| trap_taken | output | 1 | Trap accepted on the previous edge; also load-reservation invalidate |
| vec_ill | output | 1 | Vector configuration illegal |
| vec_len | output | VL_W | Vector length |

## Verification
The bench sweeps every combination of previous privilege, extension bits, interrupt flag and both delegation bits. For each trap it checks the handler level, the cause, EPC, trap value, status word and handler PC. Each mask holds the inverse pattern in the register that must not be consulted, so a design that indexes the wrong mask, the wrong bit or the wrong register routes the trap to the wrong level. A design that skips the user-level second stage, or applies it to a trap from supervisor mode, also routes to the wrong level. Directed cases cover the table-jump EPC, an NMI issued while delegation is set, an NMI while masked, and a resumable NMI. A design that let the resumable NMI touch the status word or the machine cause would show a changed readback.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    LVL_U   = 2'd0,
    LVL_S   = 2'd1,
    LVL_RSV = 2'd2,
    LVL_M   = 2'd3
  } lvl_e;

  // status word layout, bit 9 down to bit 0
  typedef struct packed {
    logic       mprv;
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       upie;
    logic       mie;
    logic       sie;
    logic       uie;
  } stat_t;

  localparam int STAT_W = $bits(stat_t);

  typedef enum logic [4:0] {
    SEL_STAT     = 5'd0,
    SEL_MDEL_EXC = 5'd1,
    SEL_MDEL_IRQ = 5'd2,
    SEL_SDEL_EXC = 5'd3,
    SEL_SDEL_IRQ = 5'd4,
    SEL_MVEC     = 5'd5,
    SEL_SVEC     = 5'd6,
    SEL_UVEC     = 5'd7,
    SEL_MCAUSE   = 5'd8,
    SEL_MEPC     = 5'd9,
    SEL_MTVAL    = 5'd10,
    SEL_SCAUSE   = 5'd11,
    SEL_SEPC     = 5'd12,
    SEL_STVAL    = 5'd13,
    SEL_UCAUSE   = 5'd14,
    SEL_UEPC     = 5'd15,
    SEL_UTVAL    = 5'd16,
    SEL_NCAUSE   = 5'd17,
    SEL_NEPC     = 5'd18,
    SEL_NSTAT    = 5'd19,
    SEL_PRIV     = 5'd20
  } sel_e;

  // level chosen when the machine-level stage delegates
  function automatic lvl_e stage1_level(input logic has_s, input logic has_u);
    if (has_s)      return LVL_S;
    else if (has_u) return LVL_U;
    else            return LVL_M;
  endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_entry_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int DEL_W  = 32
) (
  input  lvl_e              prev,
  input  logic              has_s,
  input  logic              has_u,
  input  logic              is_irq,
  input  logic              is_nmi,
  input  logic [CODE_W-1:0] code,
  input  logic [DEL_W-1:0]  mdel_exc,
  input  logic [DEL_W-1:0]  mdel_irq,
  input  logic [DEL_W-1:0]  sdel_exc,
  input  logic [DEL_W-1:0]  sdel_irq,
  output lvl_e              handler,
  output logic              stage1_hit,
  output logic              stage2_hit
);

  logic m_bit, s_bit;
  lvl_e s1_lvl;

  always_comb begin
    m_bit      = is_irq ? mdel_irq[code] : mdel_exc[code];
    s_bit      = is_irq ? sdel_irq[code] : sdel_exc[code];
    s1_lvl     = stage1_level(has_s, has_u);
    stage1_hit = !is_nmi && (prev != LVL_M) && m_bit;
    stage2_hit = stage1_hit && (s1_lvl == LVL_S) && (prev == LVL_U) &&
                 has_s && has_u && s_bit;
    if (is_nmi)          handler = LVL_M;
    else if (stage2_hit) handler = LVL_U;
    else if (stage1_hit) handler = s1_lvl;
    else                 handler = LVL_M;
  end

endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_entry_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          CODE_W  = 5,
  parameter logic [31:0] NMI_VEC = 32'h0000_0040
) (
  input  lvl_e              lvl,
  input  logic              is_irq,
  input  logic              is_nmi,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   mvec,
  input  logic [XLEN-1:0]   svec,
  input  logic [XLEN-1:0]   uvec,
  output logic [XLEN-1:0]   handler_pc
);

  function automatic logic [XLEN-1:0] vec_pc(input logic [XLEN-1:0] tvec,
                                             input logic [CODE_W-1:0] c,
                                             input logic intr);
    logic [XLEN-1:0] base;
    base = {tvec[XLEN-1:2], 2'b00};
    if (tvec[1:0] == 2'b01 && intr) return base + (XLEN'(c) << 2);
    return base;
  endfunction

  logic [XLEN-1:0] sel_vec;

  always_comb begin
    case (lvl)
      LVL_U:   sel_vec = uvec;
      LVL_S:   sel_vec = svec;
      default: sel_vec = mvec;
    endcase
    if (is_nmi) handler_pc = XLEN'(NMI_VEC);
    else        handler_pc = vec_pc(sel_vec, code, is_irq);
  end

endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
  import trap_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5,
  parameter int DEL_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  lvl_e              tgt,
  input  logic              rnmi,
  input  logic              is_irq,
  input  logic              is_nmi,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   epc_val,
  input  logic [XLEN-1:0]   tval_val,
  input  logic              wr_en,
  input  logic [4:0]        wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   rd_data,
  output lvl_e              priv_q,
  output logic              nmie_q,
  output logic [DEL_W-1:0]  mdel_exc_q,
  output logic [DEL_W-1:0]  mdel_irq_q,
  output logic [DEL_W-1:0]  sdel_exc_q,
  output logic [DEL_W-1:0]  sdel_irq_q,
  output logic [XLEN-1:0]   mvec_q,
  output logic [XLEN-1:0]   svec_q,
  output logic [XLEN-1:0]   uvec_q
);

  function automatic logic [XLEN-1:0] make_cause(input logic [CODE_W-1:0] c,
                                                 input logic intr);
    logic [XLEN-1:0] v;
    v = XLEN'(c);
    v[XLEN-1] = intr;
    return v;
  endfunction

  stat_t           stat_q;
  lvl_e            npp_q;
  logic [XLEN-1:0] mcause_q, mepc_q, mtval_q;
  logic [XLEN-1:0] scause_q, sepc_q, stval_q;
  logic [XLEN-1:0] ucause_q, uepc_q, utval_q;
  logic [XLEN-1:0] ncause_q, nepc_q;
  logic [XLEN-1:0] cause_val;
  sel_e            sel;

  assign cause_val = make_cause(code, is_irq || is_nmi);
  assign sel       = sel_e'(wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= '0;
      npp_q      <= LVL_U;
      nmie_q     <= 1'b1;
      priv_q     <= LVL_M;
      mdel_exc_q <= '0;
      mdel_irq_q <= '0;
      sdel_exc_q <= '0;
      sdel_irq_q <= '0;
      mvec_q     <= '0;
      svec_q     <= '0;
      uvec_q     <= '0;
      mcause_q   <= '0;
      mepc_q     <= '0;
      mtval_q    <= '0;
      scause_q   <= '0;
      sepc_q     <= '0;
      stval_q    <= '0;
      ucause_q   <= '0;
      uepc_q     <= '0;
      utval_q    <= '0;
      ncause_q   <= '0;
      nepc_q     <= '0;
    end else if (take) begin
      case (tgt)
        LVL_U: begin
          ucause_q    <= cause_val;
          uepc_q      <= epc_val;
          utval_q     <= tval_val;
          stat_q.upie <= stat_q.uie;
          stat_q.uie  <= 1'b0;
        end
        LVL_S: begin
          scause_q    <= cause_val;
          sepc_q      <= epc_val;
          stval_q     <= tval_val;
          stat_q.spp  <= priv_q[0];
          stat_q.spie <= stat_q.sie;
          stat_q.sie  <= 1'b0;
        end
        default: begin
          mtval_q <= tval_val;
          if (rnmi) begin
            ncause_q <= cause_val;
            nepc_q   <= epc_val;
            npp_q    <= priv_q;
          end else begin
            mcause_q    <= cause_val;
            mepc_q      <= epc_val;
            stat_q.mpp  <= priv_q;
            stat_q.mpie <= stat_q.mie;
            stat_q.mie  <= 1'b0;
          end
        end
      endcase
      priv_q <= tgt;
      if (is_nmi) nmie_q <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_STAT:     stat_q     <= stat_t'(wr_data[STAT_W-1:0]);
        SEL_MDEL_EXC: mdel_exc_q <= wr_data[DEL_W-1:0];
        SEL_MDEL_IRQ: mdel_irq_q <= wr_data[DEL_W-1:0];
        SEL_SDEL_EXC: sdel_exc_q <= wr_data[DEL_W-1:0];
        SEL_SDEL_IRQ: sdel_irq_q <= wr_data[DEL_W-1:0];
        SEL_MVEC:     mvec_q     <= wr_data;
        SEL_SVEC:     svec_q     <= wr_data;
        SEL_UVEC:     uvec_q     <= wr_data;
        SEL_MCAUSE:   mcause_q   <= wr_data;
        SEL_MEPC:     mepc_q     <= wr_data;
        SEL_MTVAL:    mtval_q    <= wr_data;
        SEL_SCAUSE:   scause_q   <= wr_data;
        SEL_SEPC:     sepc_q     <= wr_data;
        SEL_STVAL:    stval_q    <= wr_data;
        SEL_UCAUSE:   ucause_q   <= wr_data;
        SEL_UEPC:     uepc_q     <= wr_data;
        SEL_UTVAL:    utval_q    <= wr_data;
        SEL_NCAUSE:   ncause_q   <= wr_data;
        SEL_NEPC:     nepc_q     <= wr_data;
        SEL_NSTAT: begin
          npp_q  <= lvl_e'(wr_data[1:0]);
          nmie_q <= wr_data[2];
        end
        SEL_PRIV:     priv_q     <= lvl_e'(wr_data[1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_STAT:     rd_data = XLEN'(stat_q);
      SEL_MDEL_EXC: rd_data = XLEN'(mdel_exc_q);
      SEL_MDEL_IRQ: rd_data = XLEN'(mdel_irq_q);
      SEL_SDEL_EXC: rd_data = XLEN'(sdel_exc_q);
      SEL_SDEL_IRQ: rd_data = XLEN'(sdel_irq_q);
      SEL_MVEC:     rd_data = mvec_q;
      SEL_SVEC:     rd_data = svec_q;
      SEL_UVEC:     rd_data = uvec_q;
      SEL_MCAUSE:   rd_data = mcause_q;
      SEL_MEPC:     rd_data = mepc_q;
      SEL_MTVAL:    rd_data = mtval_q;
      SEL_SCAUSE:   rd_data = scause_q;
      SEL_SEPC:     rd_data = sepc_q;
      SEL_STVAL:    rd_data = stval_q;
      SEL_UCAUSE:   rd_data = ucause_q;
      SEL_UEPC:     rd_data = uepc_q;
      SEL_UTVAL:    rd_data = utval_q;
      SEL_NCAUSE:   rd_data = ncause_q;
      SEL_NEPC:     rd_data = nepc_q;
      SEL_NSTAT:    rd_data = XLEN'({nmie_q, npp_q});
      SEL_PRIV:     rd_data = XLEN'(priv_q);
      default:      rd_data = '0;
    endcase
  end

  // R5: supervisor entry moves SIE into SPIE and clears SIE
  p_s_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tgt == LVL_S) |=> (!stat_q.sie && stat_q.spie == $past(stat_q.sie)));

  // R6: ordinary machine entry moves MIE into MPIE and clears MIE
  p_m_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tgt == LVL_M && !rnmi) |=> (!stat_q.mie && stat_q.mpie == $past(stat_q.mie)));

  // R7: resumable NMI leaves the status word and machine cause untouched
  p_rnmi_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rnmi) |=> (stat_q == $past(stat_q) && mcause_q == $past(mcause_q)));

  // R10: privilege follows the chosen handler level
  p_priv_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (priv_q == $past(tgt)));

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CODE_W    = 5,
  parameter int          VL_W      = 8,
  parameter logic [31:0] RESET_VEC = 32'h0000_0100,
  parameter logic [31:0] NMI_VEC   = 32'h0000_0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic              trap_irq,
  input  logic              trap_nmi,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              tbl_second,
  input  logic [XLEN-1:0]   tbl_pc,
  input  logic [XLEN-1:0]   trap_val,
  input  logic              ext_s,
  input  logic              ext_u_irq,
  input  logic              ext_rnmi,
  input  logic              csr_we,
  input  logic [4:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic [1:0]        priv_lvl,
  output logic [XLEN-1:0]   pc_out,
  output logic              trap_taken,
  output logic              vec_ill,
  output logic [VL_W-1:0]   vec_len
);

  localparam int DEL_W = 1 << CODE_W;

  lvl_e              priv_q, handler;
  logic              nmie_q, accept, is_rnmi, stage1_hit, stage2_hit;
  logic [DEL_W-1:0]  mdel_exc, mdel_irq, sdel_exc, sdel_irq;
  logic [XLEN-1:0]   mvec, svec, uvec, handler_pc, epc_val;
  logic [XLEN-1:0]   pc_q;
  logic              taken_q, vill_q;
  logic [VL_W-1:0]   vl_q;

  assign accept  = trap_req && (!trap_nmi || nmie_q);
  assign is_rnmi = trap_nmi && ext_rnmi;
  assign epc_val = tbl_second ? tbl_pc : trap_pc;

  trap_route #(.CODE_W(CODE_W), .DEL_W(DEL_W)) u_route (
    .prev(priv_q), .has_s(ext_s), .has_u(ext_u_irq),
    .is_irq(trap_irq), .is_nmi(trap_nmi), .code(trap_code),
    .mdel_exc(mdel_exc), .mdel_irq(mdel_irq),
    .sdel_exc(sdel_exc), .sdel_irq(sdel_irq),
    .handler(handler), .stage1_hit(stage1_hit), .stage2_hit(stage2_hit)
  );

  trap_target #(.XLEN(XLEN), .CODE_W(CODE_W), .NMI_VEC(NMI_VEC)) u_target (
    .lvl(handler), .is_irq(trap_irq), .is_nmi(trap_nmi), .code(trap_code),
    .mvec(mvec), .svec(svec), .uvec(uvec), .handler_pc(handler_pc)
  );

  trap_csr_file #(.XLEN(XLEN), .CODE_W(CODE_W), .DEL_W(DEL_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .take(accept), .tgt(handler), .rnmi(is_rnmi),
    .is_irq(trap_irq), .is_nmi(trap_nmi), .code(trap_code),
    .epc_val(epc_val), .tval_val(trap_val),
    .wr_en(csr_we), .wr_sel(csr_sel), .wr_data(csr_wdata), .rd_data(csr_rdata),
    .priv_q(priv_q), .nmie_q(nmie_q),
    .mdel_exc_q(mdel_exc), .mdel_irq_q(mdel_irq),
    .sdel_exc_q(sdel_exc), .sdel_irq_q(sdel_irq),
    .mvec_q(mvec), .svec_q(svec), .uvec_q(uvec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= XLEN'(RESET_VEC);
      taken_q <= 1'b0;
      vill_q  <= 1'b1;
      vl_q    <= '0;
    end else begin
      taken_q <= accept;
      if (accept) pc_q <= handler_pc;
    end
  end

  assign priv_lvl   = priv_q;
  assign pc_out     = pc_q;
  assign trap_taken = taken_q;
  assign vec_ill    = vill_q;
  assign vec_len    = vl_q;

  // R2: an NMI is always handled at machine level
  p_nmi_to_m_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_nmi) |-> (handler == LVL_M));

  // R3: a trap raised at machine level is never delegated
  p_m_no_deleg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && priv_q == LVL_M) |-> (handler == LVL_M && !stage1_hit));

  // R4: the user-level stage only fires for traps raised in user mode
  p_stage2_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stage2_hit |-> (priv_q == LVL_U && stage1_hit));

  // R11: handler addresses are word aligned
  p_pc_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> (pc_out[1:0] == 2'b00));

endmodule

// File: tb/test_trap_entry_ctrl.sv
module test_trap_entry_ctrl;
  localparam int          XLEN = 32;
  localparam int          CODE_W = 5;
  localparam int          VL_W = 8;
  localparam logic [31:0] RVEC = 32'h0000_0100;
  localparam logic [31:0] NVEC = 32'h0000_0040;

  logic clk = 0, rst_n = 0;
  logic trap_req = 0, trap_irq = 0, trap_nmi = 0, tbl_second = 0;
  logic [CODE_W-1:0] trap_code = '0;
  logic [XLEN-1:0] trap_pc = '0, tbl_pc = '0, trap_val = '0, csr_wdata = '0;
  logic ext_s = 0, ext_u_irq = 0, ext_rnmi = 0, csr_we = 0;
  logic [4:0] csr_sel = '0;
  logic [XLEN-1:0] csr_rdata, pc_out;
  logic [1:0] priv_lvl;
  logic trap_taken, vec_ill;
  logic [VL_W-1:0] vec_len;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  trap_entry_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W), .VL_W(VL_W),
                    .RESET_VEC(RVEC), .NMI_VEC(NVEC)) i_trap_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
    .trap_nmi(trap_nmi), .trap_code(trap_code), .trap_pc(trap_pc),
    .tbl_second(tbl_second), .tbl_pc(tbl_pc), .trap_val(trap_val),
    .ext_s(ext_s), .ext_u_irq(ext_u_irq), .ext_rnmi(ext_rnmi),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .priv_lvl(priv_lvl), .pc_out(pc_out),
    .trap_taken(trap_taken), .vec_ill(vec_ill), .vec_len(vec_len)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1; csr_sel = 5'(sel); csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 0;
  endtask

  task automatic rd(input int sel, output logic [31:0] d);
    csr_sel = 5'(sel); #1; d = csr_rdata;
  endtask

  task automatic fire(input logic irq, input logic nmi, input logic [4:0] code,
                      input logic [31:0] pc, input logic [31:0] val);
    @(negedge clk);
    trap_req = 1; trap_irq = irq; trap_nmi = nmi; trap_code = code;
    trap_pc = pc; trap_val = val;
    @(posedge clk); #1;
    trap_req = 0; trap_irq = 0; trap_nmi = 0;
  endtask

  // handler level written as a table per previous level
  function automatic int exp_level(int prev, bit s, bit u, bit md, bit sd);
    int first;
    case (prev)
      3: return 3;
      default: begin
        if (!md) return 3;
        first = s ? 1 : (u ? 0 : 3);
        if (prev == 0 && first == 1 && u && sd) return 0;
        return first;
      end
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, st, exp_pc, exp_cause, base;
    int h, idx;
    // R1: reset state
    #25; rst_n = 1; #1;
    chk("R1 priv", 32'(priv_lvl), 3);
    chk("R1 pc", pc_out, RVEC);
    chk("R1 vec_ill", 32'(vec_ill), 1);
    chk("R1 vec_len", 32'(vec_len), 0);
    chk("R1 trap_taken", 32'(trap_taken), 0);
    rd(0, r);  chk("R1 status", r, 0);
    rd(19, r); chk("R1 nmi status", r, 32'h4);

    // R12: vectors: machine vectored, supervisor direct, user vectored
    wr(5, 32'h0000_1001);
    wr(6, 32'h0000_2000);
    wr(7, 32'h0000_3001);
    rd(6, r); chk("R12 svec readback", r, 32'h0000_2000);

    idx = 0;
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 2; s++)
        for (int u = 0; u < 2; u++)
          for (int irq = 0; irq < 2; irq++)
            for (int md = 0; md < 2; md++)
              for (int sd = 0; sd < 2; sd++) begin
                automatic int prev = (p == 2) ? 3 : p;
                automatic logic [4:0] code = 5'((idx * 7 + 3) % 32);
                automatic logic [31:0] bitv = 32'h1 << code;
                automatic logic [31:0] mpat = md ? bitv : ~bitv;
                automatic logic [31:0] spat = sd ? bitv : ~bitv;
                // matching mask gets the pattern, the other mask its inverse
                wr(irq ? 2 : 1, mpat);
                wr(irq ? 1 : 2, ~mpat);
                wr(irq ? 4 : 3, spat);
                wr(irq ? 3 : 4, ~spat);
                wr(0, 32'h7);
                wr(20, 32'(prev));
                ext_s = 1'(s); ext_u_irq = 1'(u);
                fire(1'(irq), 0, code, 32'h8000_0000 + 32'(idx * 4), 32'hBEEF_0000 + 32'(idx));
                h = exp_level(prev, 1'(s), 1'(u), 1'(md), 1'(sd));
                chk("R10 trap_taken", 32'(trap_taken), 1);
                chk("R3 R4 handler priv", 32'(priv_lvl), 32'(h));
                exp_cause = 32'(code) | (irq ? 32'h8000_0000 : 0);
                base = (h == 3) ? 32'h1000 : (h == 1) ? 32'h2000 : 32'h3000;
                exp_pc = base + ((h != 1 && irq) ? 32'(code) * 4 : 0);
                chk("R11 handler pc", pc_out, exp_pc);
                rd(h == 3 ? 8 : h == 1 ? 11 : 14, r);  chk("R8 cause", r, exp_cause);
                rd(h == 3 ? 9 : h == 1 ? 12 : 15, r);  chk("R9 epc", r, 32'h8000_0000 + 32'(idx * 4));
                rd(h == 3 ? 10 : h == 1 ? 13 : 16, r); chk("R10 tval", r, 32'hBEEF_0000 + 32'(idx));
                st = 32'h7;
                if (h == 3)      st = (st & ~32'h184 & ~32'h20) | (32'(prev) << 7) | 32'h20;
                else if (h == 1) st = (st & ~32'h52) | (32'(prev & 1) << 6) | 32'h10;
                else             st = (st & ~32'h9) | 32'h8;
                rd(0, r); chk(h == 3 ? "R6 status" : "R5 status", r, st);
                idx++;
              end

    // R10: strobe lasts one cycle
    @(posedge clk); #1;
    chk("R10 strobe drops", 32'(trap_taken), 0);

    // R9: table-jump second fetch saves the table-jump pc
    wr(20, 3); wr(0, 0);
    tbl_second = 1; tbl_pc = 32'h0000_4444;
    fire(0, 0, 5'd2, 32'h0000_5550, 32'h11);
    tbl_second = 0;
    rd(9, r); chk("R9 table-jump epc", r, 32'h0000_4444);
    chk("R11 exception direct pc", pc_out, 32'h1000);

    // R2: non-resumable NMI from S with delegation set still goes to M
    ext_s = 1; ext_u_irq = 1; ext_rnmi = 0;
    wr(2, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
    wr(0, 32'h7); wr(20, 1);
    fire(0, 1, 5'd0, 32'h0000_6000, 32'h22);
    chk("R2 nmi priv", 32'(priv_lvl), 3);
    chk("R2 nmi pc", pc_out, NVEC);
    rd(8, r);  chk("R8 nmi cause", r, 32'h8000_0000);
    rd(0, r);  chk("R6 nmi status", r, 32'h0A3);
    rd(19, r); chk("R2 nmie cleared", r, 32'h0);

    // R2: NMI while masked is ignored
    wr(20, 1);
    fire(0, 1, 5'd1, 32'h0000_7000, 32'h33);
    chk("R2 masked nmi no strobe", 32'(trap_taken), 0);
    chk("R2 masked nmi priv", 32'(priv_lvl), 1);
    chk("R2 masked nmi pc", pc_out, NVEC);
    rd(9, r); chk("R2 masked nmi epc", r, 32'h0000_6000);

    // R7: resumable NMI from U
    ext_rnmi = 1;
    wr(19, 32'h4); wr(0, 32'h7); wr(8, 32'h55); wr(20, 0);
    fire(0, 1, 5'd3, 32'h0000_8000, 32'h44);
    chk("R7 rnmi priv", 32'(priv_lvl), 3);
    chk("R7 rnmi pc", pc_out, NVEC);
    rd(17, r); chk("R7 rnmi cause", r, 32'h8000_0003);
    rd(18, r); chk("R7 rnmi epc", r, 32'h0000_8000);
    rd(19, r); chk("R7 rnmi status", r, 32'h0);
    rd(0, r);  chk("R7 status kept", r, 32'h7);
    rd(8, r);  chk("R7 mcause kept", r, 32'h55);
    rd(10, r); chk("R10 rnmi tval", r, 32'h44);
    ext_rnmi = 0;

    // R1: reset mid-run
    wr(0, 32'h3FF); wr(20, 1);
    @(negedge clk); rst_n = 0; #5;
    chk("R1 priv in reset", 32'(priv_lvl), 3);
    @(negedge clk); rst_n = 1; #1;
    rd(0, r); chk("R1 status after reset", r, 0);
    chk("R1 pc after reset", pc_out, RVEC);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule